// File: doc/BRIEF.md
# SPI Buffer Status Flag Generator

This block builds the status flags of an SPI peripheral. Its inputs are event pulses from the shift engine (a word moving from the transmit buffer into the transmit shift register, a word finishing its shift-out, a received word moving into the receive buffer), from the register interface (software writes and reads of the data register), and from the framing and underrun logic. From these it keeps buffer occupancy and sticky error flags. Software clears the error flags with a strobe and a bit mask.

It has two ways of deriving the flags. In single-buffer mode each direction holds at most one word, and the full and empty flags are set and cleared by the events that fill or drain that word. In enhanced mode the block keeps a saturating element count per direction. Empty means a count of zero and full means a count at its all-ones maximum. The transmit underrun flag is either sticky, in which case it raises a halt request to the shift engine until it is cleared, or a live copy of the underrun condition when underruns are to be ignored.

Top module: `spi_status_gen`

## Requirements
- R1: After reset, txEmpty and rxEmpty are 1, and txFull, rxFull, rxOvf, txUnderrun, frameErr, busy and haltReq are 0.
- R2: With enhMode=0, a swWrite pulse makes txFull=1 and txEmpty=0 from the next cycle, and a txLoad pulse makes txFull=0 and txEmpty=1. If both arrive in the same cycle while the buffer holds a word, the buffer stays full.
- R3: With enhMode=0, an rxLoad pulse makes rxFull=1 and rxEmpty=0 from the next cycle, and a swRead pulse makes rxFull=0 and rxEmpty=1.
- R4: With enhMode=1, each direction keeps a CNT_W-bit count. Transmit pushes on swWrite and pops on txLoad; receive pushes on rxLoad and pops on swRead. Empty means count 0 and full means count 2^CNT_W-1. The count saturates at both ends, and a push and a pop in the same cycle leave it unchanged.
- R5: An rxLoad pulse while rxFull=1 sets rxOvf from the next cycle. rxOvf stays set until it is cleared through clrMask bit 0.
- R6: srEmpty is 1 only when the transmit buffer is empty and the shift register holds no word. A word enters the shift register on txLoad and leaves it on txShiftDone.
- R7: With ignUnderrun=0 and enable=1, underrunIn=1 sets a sticky underrun flag from the next cycle. While the flag is set, txUnderrun=1 and haltReq=1. It stays set until cleared through clrMask bit 1.
- R8: With ignUnderrun=1, txUnderrun equals enable AND underrunIn in the same cycle, haltReq is 0, and no software clear is needed.
- R9: While enable=0, txUnderrun and haltReq are 0, and any sticky underrun state is discarded so that it does not reappear after re-enable.
- R10: frameErrIn=1 sets frameErr from the next cycle. frameErr stays set until cleared through clrMask bit 2.
- R11: A clrStb pulse clears only the sticky flags whose clrMask bit is set. A set event in the same cycle as its clear wins.
- R12: busy shows busyIn delayed by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Module enable |
| enhMode | input | 1 | 0 = single-buffer flags, 1 = count-derived flags |
| ignUnderrun | input | 1 | 1 = underrun flag is live and non-halting |
| swWrite | input | 1 | Software write of the data register (pulse) |
| swRead | input | 1 | Software read of the data register (pulse) |
| txLoad | input | 1 | Transmit buffer to shift register move (pulse) |
| txShiftDone | input | 1 | Transmit shift register emptied (pulse) |
| rxLoad | input | 1 | Receive shift register to buffer move (pulse) |
| frameErrIn | input | 1 | Frame error detected (pulse) |
| underrunIn | input | 1 | Underrun condition (level) |
| busyIn | input | 1 | Transaction in progress |
| clrStb | input | 1 | Software clear strobe |
| clrMask | input | 3 | Clear mask: bit0 rxOvf, bit1 underrun, bit2 frameErr |
| txFull | output | 1 | Transmit buffer full |
| txEmpty | output | 1 | Transmit buffer empty |
| rxFull | output | 1 | Receive buffer full |
| rxEmpty | output | 1 | Receive buffer empty |
| srEmpty | output | 1 | No transmit word pending or shifting |
| busy | output | 1 | Activity status |
| rxOvf | output | 1 | Sticky receive overflow |
| txUnderrun | output | 1 | Underrun status |
| frameErr | output | 1 | Sticky frame error |
| haltReq | output | 1 | Halt request to the shift engine |

## Verification
The bench builds the block with CNT_W=3, so the enhanced-mode counts top out at 7. Filling a direction to full, pushing past saturation, popping from empty and mixing simultaneous push and pop then take only a handful of cycles each. Single-buffer behaviour does not depend on CNT_W, so it is exercised in full at the same setting.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;

  // Clear-mask bit positions
  localparam int CLR_OVF = 0;
  localparam int CLR_UR  = 1;
  localparam int CLR_FE  = 2;
  localparam int CLR_W   = 3;

  // Strobes from control to datapath
  typedef struct packed {
    logic txPush;
    logic txPop;
    logic rxPush;
    logic rxPop;
    logic srLoad;
    logic srDone;
    logic ovfSet;
    logic ovfClr;
    logic urSet;
    logic urClr;
    logic urFlush;
    logic feSet;
    logic feClr;
  } ctlStrobes_t;

endpackage

// File: rtl/spi_stat_cnt.sv
module spi_stat_cnt #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (push && !pop) begin
      if (cnt < limit) cnt <= cnt + CNT_W'(1);
    end else if (pop && !push) begin
      if (cnt != '0) cnt <= cnt - CNT_W'(1);
    end
  end

endmodule

// File: rtl/spi_stat_ctrl.sv
module spi_stat_ctrl
  import spi_stat_pkg::*;
(
  input  logic             enable,
  input  logic             ignUnderrun,
  input  logic             swWrite,
  input  logic             swRead,
  input  logic             txLoad,
  input  logic             txShiftDone,
  input  logic             rxLoad,
  input  logic             frameErrIn,
  input  logic             underrunIn,
  input  logic             clrStb,
  input  logic [CLR_W-1:0] clrMask,
  input  logic             rxFullNow,
  output ctlStrobes_t      stb
);

  always_comb begin
    stb         = '0;
    stb.txPush  = swWrite;
    stb.txPop   = txLoad;
    stb.rxPush  = rxLoad;
    stb.rxPop   = swRead;
    stb.srLoad  = txLoad;
    stb.srDone  = txShiftDone;
    stb.ovfSet  = rxLoad && rxFullNow;
    stb.ovfClr  = clrStb && clrMask[CLR_OVF];
    stb.urSet   = enable && underrunIn && !ignUnderrun;
    stb.urClr   = clrStb && clrMask[CLR_UR];
    stb.urFlush = !enable;
    stb.feSet   = frameErrIn;
    stb.feClr   = clrStb && clrMask[CLR_FE];
  end

endmodule

// File: rtl/spi_stat_dp.sv
module spi_stat_dp
  import spi_stat_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t stb,
  input  logic        enable,
  input  logic        enhMode,
  input  logic        ignUnderrun,
  input  logic        underrunIn,
  input  logic        busyIn,
  output logic        txFull,
  output logic        txEmpty,
  output logic        rxFull,
  output logic        rxEmpty,
  output logic        srEmpty,
  output logic        busy,
  output logic        rxOvf,
  output logic        txUnderrun,
  output logic        frameErr,
  output logic        haltReq
);

  localparam int               NDIR    = 2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] limit;
  logic [NDIR-1:0]  pushV, popV;
  logic [CNT_W-1:0] cntV [NDIR];
  logic [NDIR-1:0]  fullV, emptyV;

  logic srHeld;
  logic urSticky;

  assign limit = enhMode ? CNT_MAX : CNT_ONE;
  assign pushV = {stb.rxPush, stb.txPush};
  assign popV  = {stb.rxPop,  stb.txPop};

  // Index 0 = transmit, 1 = receive
  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    spi_stat_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rstN  (rstN),
      .push  (pushV[d]),
      .pop   (popV[d]),
      .limit (limit),
      .cnt   (cntV[d])
    );
    assign fullV[d]  = (cntV[d] >= limit);
    assign emptyV[d] = (cntV[d] == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srHeld   <= 1'b0;
      rxOvf    <= 1'b0;
      urSticky <= 1'b0;
      frameErr <= 1'b0;
      busy     <= 1'b0;
    end else begin
      if (stb.srLoad)      srHeld <= 1'b1;
      else if (stb.srDone) srHeld <= 1'b0;

      if (stb.ovfSet)      rxOvf <= 1'b1;
      else if (stb.ovfClr) rxOvf <= 1'b0;

      if (stb.urFlush)     urSticky <= 1'b0;
      else if (stb.urSet)  urSticky <= 1'b1;
      else if (stb.urClr)  urSticky <= 1'b0;

      if (stb.feSet)       frameErr <= 1'b1;
      else if (stb.feClr)  frameErr <= 1'b0;

      busy <= busyIn;
    end
  end

  assign txFull     = fullV[0];
  assign txEmpty    = emptyV[0];
  assign rxFull     = fullV[1];
  assign rxEmpty    = emptyV[1];
  assign srEmpty    = emptyV[0] && !srHeld;
  assign txUnderrun = enable && (ignUnderrun ? underrunIn : urSticky);
  assign haltReq    = enable && !ignUnderrun && urSticky;

endmodule

// File: rtl/spi_status_gen.sv
module spi_status_gen
  import spi_stat_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             enhMode,
  input  logic             ignUnderrun,
  input  logic             swWrite,
  input  logic             swRead,
  input  logic             txLoad,
  input  logic             txShiftDone,
  input  logic             rxLoad,
  input  logic             frameErrIn,
  input  logic             underrunIn,
  input  logic             busyIn,
  input  logic             clrStb,
  input  logic [CLR_W-1:0] clrMask,
  output logic             txFull,
  output logic             txEmpty,
  output logic             rxFull,
  output logic             rxEmpty,
  output logic             srEmpty,
  output logic             busy,
  output logic             rxOvf,
  output logic             txUnderrun,
  output logic             frameErr,
  output logic             haltReq
);

  ctlStrobes_t stb;

  spi_stat_ctrl u_ctrl (
    .enable      (enable),
    .ignUnderrun (ignUnderrun),
    .swWrite     (swWrite),
    .swRead      (swRead),
    .txLoad      (txLoad),
    .txShiftDone (txShiftDone),
    .rxLoad      (rxLoad),
    .frameErrIn  (frameErrIn),
    .underrunIn  (underrunIn),
    .clrStb      (clrStb),
    .clrMask     (clrMask),
    .rxFullNow   (rxFull),
    .stb         (stb)
  );

  spi_stat_dp #(.CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .enable      (enable),
    .enhMode     (enhMode),
    .ignUnderrun (ignUnderrun),
    .underrunIn  (underrunIn),
    .busyIn      (busyIn),
    .txFull      (txFull),
    .txEmpty     (txEmpty),
    .rxFull      (rxFull),
    .rxEmpty     (rxEmpty),
    .srEmpty     (srEmpty),
    .busy        (busy),
    .rxOvf       (rxOvf),
    .txUnderrun  (txUnderrun),
    .frameErr    (frameErr),
    .haltReq     (haltReq)
  );

endmodule

// File: rtl/spi_status_gen_chk.sv
module spi_status_gen_chk (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic enhMode,
  input logic ignUnderrun,
  input logic swWrite,
  input logic txLoad,
  input logic rxLoad,
  input logic frameErrIn,
  input logic underrunIn,
  input logic busyIn,
  input logic txFull,
  input logic txEmpty,
  input logic rxFull,
  input logic rxEmpty,
  input logic srEmpty,
  input logic busy,
  input logic rxOvf,
  input logic txUnderrun,
  input logic frameErr,
  input logic haltReq
);

  AST_TX_SET_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (!enhMode && swWrite && !txLoad) |=> (enhMode || (txFull && !txEmpty))); // R2
  AST_TX_NOT_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    !(txFull && txEmpty)); // R2
  AST_RX_SET_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (!enhMode && rxLoad) |=> (enhMode || (rxFull && !rxEmpty))); // R3
  AST_ENH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (enhMode && swWrite && txLoad) |=> (!enhMode || ($stable(txFull) && $stable(txEmpty)))); // R4
  AST_NO_OVERFLOW_MISS: assert property (@(posedge clk) disable iff (!rstN)
    (rxLoad && rxFull) |=> rxOvf); // R5
  AST_SR_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    srEmpty |-> txEmpty); // R6
  AST_UR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !ignUnderrun && underrunIn) |=> (!enable || ignUnderrun || (txUnderrun && haltReq))); // R7
  AST_UR_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    ignUnderrun |-> (!haltReq && (txUnderrun == (enable && underrunIn)))); // R8
  AST_UR_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (!txUnderrun && !haltReq)); // R9
  AST_FE_SET: assert property (@(posedge clk) disable iff (!rstN)
    frameErrIn |=> frameErr); // R10
  AST_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busyIn |=> busy); // R12

endmodule

bind spi_status_gen spi_status_gen_chk u_chk (.*);

// File: tb/sim_spi_status_gen.sv
`timescale 1ns/1ps
module sim_spi_status_gen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b1, enhMode = 1'b0, ignUnderrun = 1'b0;
  logic       swWrite = 1'b0, swRead = 1'b0, txLoad = 1'b0, txShiftDone = 1'b0;
  logic       rxLoad = 1'b0, frameErrIn = 1'b0, underrunIn = 1'b0, busyIn = 1'b0;
  logic       clrStb = 1'b0;
  logic [2:0] clrMask = 3'b000;
  logic txFull, txEmpty, rxFull, rxEmpty, srEmpty, busy, rxOvf, txUnderrun, frameErr, haltReq;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  spi_status_gen #(.CNT_W(3)) u0 (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  // Drive pulses for one cycle; results visible at the following negedge
  task automatic pulse(input logic w, r, tl, sd, rl);
    step();
    swWrite = w; swRead = r; txLoad = tl; txShiftDone = sd; rxLoad = rl;
    step();
    swWrite = 0; swRead = 0; txLoad = 0; txShiftDone = 0; rxLoad = 0;
  endtask

  task automatic clr(input logic [2:0] m);
    step(); clrStb = 1; clrMask = m;
    step(); clrStb = 0; clrMask = 0;
  endtask

  task automatic tReset();
    chk("R1 txEmpty", txEmpty, 1); chk("R1 rxEmpty", rxEmpty, 1);
    chk("R1 txFull", txFull, 0);   chk("R1 rxFull", rxFull, 0);
    chk("R1 rxOvf", rxOvf, 0);     chk("R1 txUnderrun", txUnderrun, 0);
    chk("R1 frameErr", frameErr, 0); chk("R1 busy", busy, 0);
    chk("R1 haltReq", haltReq, 0);
  endtask

  task automatic tSingleTx();
    pulse(1, 0, 0, 0, 0);
    chk("R2 txFull after write", txFull, 1); chk("R2 txEmpty after write", txEmpty, 0);
    pulse(1, 0, 1, 0, 0);
    chk("R2 full kept on write+load", txFull, 1);
    pulse(0, 0, 1, 0, 0);
    chk("R2 txFull after load", txFull, 0); chk("R2 txEmpty after load", txEmpty, 1);
    pulse(0, 0, 0, 1, 0);
  endtask

  task automatic tSingleRx();
    pulse(0, 0, 0, 0, 1);
    chk("R3 rxFull after rxLoad", rxFull, 1); chk("R3 rxEmpty after rxLoad", rxEmpty, 0);
    pulse(0, 1, 0, 0, 0);
    chk("R3 rxFull after read", rxFull, 0); chk("R3 rxEmpty after read", rxEmpty, 1);
  endtask

  task automatic tOverflow();
    pulse(0, 0, 0, 0, 1);
    chk("R5 no ovf on first word", rxOvf, 0);
    pulse(0, 0, 0, 0, 1);
    chk("R5 ovf set", rxOvf, 1);
    pulse(0, 1, 0, 0, 0);
    chk("R5 ovf sticky after read", rxOvf, 1);
    clr(3'b110);
    chk("R11 ovf kept without mask bit0", rxOvf, 1);
    clr(3'b001);
    chk("R5 ovf cleared", rxOvf, 0);
  endtask

  task automatic tEnhanced();
    step(); enhMode = 1;
    for (int i = 0; i < 6; i++) pulse(1, 0, 0, 0, 0);
    chk("R4 not full at 6", txFull, 0); chk("R4 not empty at 6", txEmpty, 0);
    pulse(1, 0, 0, 0, 0);
    chk("R4 full at 7", txFull, 1);
    pulse(1, 0, 0, 0, 0);
    chk("R4 saturate at max", txFull, 1);
    pulse(0, 0, 1, 0, 0);
    chk("R4 not full after one pop", txFull, 0);
    pulse(1, 0, 1, 0, 0);
    chk("R4 push+pop holds", txFull, 0);
    pulse(1, 0, 0, 0, 0);
    chk("R4 full again proves count 6 held", txFull, 1);
    for (int i = 0; i < 6; i++) pulse(0, 0, 1, 0, 0);
    chk("R4 one left", txEmpty, 0);
    pulse(0, 0, 1, 0, 0);
    chk("R4 empty", txEmpty, 1);
    pulse(0, 0, 1, 0, 0);
    pulse(1, 0, 0, 0, 0);
    chk("R4 pop at zero saturates", txEmpty, 0);
    pulse(0, 0, 1, 0, 0);
    chk("R4 back to empty", txEmpty, 1);
    pulse(0, 0, 0, 1, 0);
    for (int i = 0; i < 7; i++) pulse(0, 0, 0, 0, 1);
    chk("R4 rx full at 7", rxFull, 1);
    chk("R5 no ovf filling enhanced", rxOvf, 0);
    pulse(0, 0, 0, 0, 1);
    chk("R5 ovf enhanced", rxOvf, 1);
    for (int i = 0; i < 7; i++) pulse(0, 1, 0, 0, 0);
    chk("R4 rx empty after drain", rxEmpty, 1);
    clr(3'b001);
    step(); enhMode = 0;
  endtask

  task automatic tSrEmpty();
    chk("R6 srEmpty idle", srEmpty, 1);
    pulse(1, 0, 0, 0, 0);
    chk("R6 srEmpty 0 with buffered word", srEmpty, 0);
    pulse(0, 0, 1, 0, 0);
    chk("R6 srEmpty 0 while shifting", srEmpty, 0);
    pulse(0, 0, 0, 1, 0);
    chk("R6 srEmpty after shift done", srEmpty, 1);
  endtask

  task automatic tUnderrunSticky();
    step(); underrunIn = 1;
    step(); underrunIn = 0;
    chk("R7 ur set", txUnderrun, 1); chk("R7 halt set", haltReq, 1);
    step();
    chk("R7 ur sticky", txUnderrun, 1);
    clr(3'b101);
    chk("R11 ur kept without mask bit1", txUnderrun, 1);
    step(); underrunIn = 1; clrStb = 1; clrMask = 3'b010;
    step(); underrunIn = 0; clrStb = 0; clrMask = 0;
    chk("R11 set wins over clear", txUnderrun, 1);
    clr(3'b010);
    chk("R7 ur cleared", txUnderrun, 0); chk("R7 halt cleared", haltReq, 0);
  endtask

  task automatic tUnderrunIgnore();
    step(); ignUnderrun = 1; underrunIn = 1; #1;
    chk("R8 live high", txUnderrun, 1); chk("R8 no halt", haltReq, 0);
    step(); underrunIn = 0; #1;
    chk("R8 live low", txUnderrun, 0);
    step(); ignUnderrun = 0; #1;
    chk("R8 no sticky left", txUnderrun, 0);
  endtask

  task automatic tDisable();
    step(); underrunIn = 1;
    step(); underrunIn = 0;
    chk("R7 set before disable", txUnderrun, 1);
    enable = 0; #1;
    chk("R9 ur off when disabled", txUnderrun, 0); chk("R9 halt off", haltReq, 0);
    step(); step(); enable = 1; #1;
    chk("R9 ur not back after enable", txUnderrun, 0);
  endtask

  task automatic tFrameBusy();
    step(); frameErrIn = 1;
    step(); frameErrIn = 0;
    chk("R10 frameErr set", frameErr, 1);
    clr(3'b011);
    chk("R11 frameErr kept without bit2", frameErr, 1);
    clr(3'b100);
    chk("R10 frameErr cleared", frameErr, 0);
    step(); busyIn = 1; #1;
    chk("R12 busy delayed", busy, 0);
    step();
    chk("R12 busy high", busy, 1);
    busyIn = 0;
    step();
    chk("R12 busy low", busy, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1;
    step();
    tReset();
    tSingleTx();
    tSingleRx();
    tOverflow();
    tSrEmpty();
    tEnhanced();
    tUnderrunSticky();
    tUnderrunIgnore();
    tDisable();
    tFrameBusy();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule